// File: doc/BRIEF.md
# Sample-and-Hold Phase Timing Sequencer

This block produces the three phase strobes that drive a low-power sample-and-hold output stage: a sampling phase, a holding phase, and periodic refresh phases. All phase lengths are counted in periods of a slow low-speed clock. The slow clock enters the block as a one-cycle enable pulse, `slow_tick`, that is already aligned to the fast system clock `clk`. Each enabled run begins with one sampling phase. After that the sequencer alternates between holding and refreshing for as long as the channel stays enabled in sample-and-hold mode.

A small write port loads four words. The control word holds the channel enable, a calibration enable and a 3-bit output mode. The other three words hold the sampling, holding and refresh lengths. Several writes are ignored depending on the current enable and calibration state. Writes to the sampling length pass through a busy window that models the transfer into the slow clock domain, and a write that arrives while that window is open is dropped. The stored fields are brought out as outputs so that the effect of every write can be observed.

Top module: `sh_timing_seq`

## Requirements
- R1: After a synchronous reset, all phase strobes, `busy`, `chan_en`, `cal_en`, `mode` and all three length fields are 0.
- R2: A control write (`wr_addr`=0) always loads `chan_en` from data bit 0. Data bit 1 loads `cal_en` only if `chan_en` was 0 before the write. Data bits 4:2 load `mode` only if both `chan_en` and `cal_en` were 0 before the write. Otherwise those fields keep their values.
- R3: A write of the hold length (`wr_addr`=2, 10 low bits) or of the refresh length (`wr_addr`=3, 8 low bits) takes effect only while `chan_en` is 0. Otherwise it is ignored.
- R4: A write of the sampling length (`wr_addr`=1, 10 low bits) is accepted when `chan_en` is 0 or `busy` is 0, using the values held before that clock edge. When `chan_en` and `busy` are both 1, the write is ignored.
- R5: `busy` rises on the clock edge that accepts a sampling-length write, and on the edge where the sequencer starts a run. It falls on the 3rd `slow_tick` seen while it is high. A new set restarts that count.
- R6: The sequencer runs only while `chan_en`=1, `cal_en`=0 and `mode` bit 2 = 1 (the sample-and-hold modes 4 to 7). On the clock edge after it becomes runnable, `ph_sample` goes high.
- R7: Each phase lasts for the number of `slow_tick` pulses given by its length field, and a field of 0 gives a phase of one pulse.
- R8: The phase order is sample, hold, refresh, hold, refresh, and so on. At most one strobe is high at any time, and sampling never reappears within a run.
- R9: On the clock edge after the run conditions are lost, all strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| slow_tick | input | 1 | One-cycle pulse per low-speed clock period |
| wr_valid | input | 1 | Write strobe |
| wr_addr | input | 2 | Word select: 0 control, 1 sampling, 2 hold, 3 refresh |
| wr_data | input | 16 | Write data |
| ph_sample | output | 1 | Sampling phase strobe |
| ph_hold | output | 1 | Holding phase strobe |
| ph_refresh | output | 1 | Refresh phase strobe |
| busy | output | 1 | Sampling-length transfer in progress |
| chan_en | output | 1 | Stored channel enable |
| cal_en | output | 1 | Stored calibration enable |
| mode | output | 3 | Stored output mode |
| sample_time | output | 10 | Stored sampling length |
| hold_time | output | 10 | Stored hold length |
| refresh_time | output | 8 | Stored refresh length |

## Verification
The sharp collision is a sampling-length write that arrives in the same cycle as the `slow_tick` that ends the busy window. The bench sets this up by accepting one write, giving two ticks, and then presenting a third tick together with a second write. The write must be dropped, because `busy` is still high at that edge, while `busy` itself falls. A second overlap is a phase boundary that falls on the edge where the channel is disabled, and the disable must win. The behavioural reference model is compared against every output on every clock.

// File: rtl/sh_seq_pkg.sv
package sh_seq_pkg;
  localparam logic [1:0] REG_CTRL    = 2'd0;
  localparam logic [1:0] REG_SAMPLE  = 2'd1;
  localparam logic [1:0] REG_HOLD    = 2'd2;
  localparam logic [1:0] REG_REFRESH = 2'd3;

  localparam int CTRL_EN_BIT  = 0;
  localparam int CTRL_CAL_BIT = 1;
  localparam int CTRL_MODE_LO = 2;
  localparam int MODE_W       = 3;
  localparam int MODE_SH_BIT  = 2;
endpackage

// File: rtl/sh_cfg_regs.sv
module sh_cfg_regs
  import sh_seq_pkg::*;
#(
  parameter int SAMPLE_W  = 10,
  parameter int HOLD_W    = 10,
  parameter int REFRESH_W = 8,
  parameter int WR_W      = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_valid,
  input  logic [1:0]           wr_addr,
  input  logic [WR_W-1:0]      wr_data,
  input  logic                 busy,
  output logic                 en_q,
  output logic                 cal_q,
  output logic [MODE_W-1:0]    mode_q,
  output logic [SAMPLE_W-1:0]  sample_q,
  output logic [HOLD_W-1:0]    hold_q,
  output logic [REFRESH_W-1:0] refresh_q,
  output logic                 samp_accept
);
  localparam int MODE_HI = CTRL_MODE_LO + MODE_W - 1;

  assign samp_accept = wr_valid && (wr_addr == REG_SAMPLE) && (!en_q || !busy);

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q      <= 1'b0;
      cal_q     <= 1'b0;
      mode_q    <= '0;
      sample_q  <= '0;
      hold_q    <= '0;
      refresh_q <= '0;
    end else begin
      if (wr_valid && wr_addr == REG_CTRL) begin
        en_q <= wr_data[CTRL_EN_BIT];
        if (!en_q) cal_q <= wr_data[CTRL_CAL_BIT];
        if (!en_q && !cal_q) mode_q <= wr_data[MODE_HI:CTRL_MODE_LO];
      end
      if (samp_accept) sample_q <= wr_data[SAMPLE_W-1:0];
      if (wr_valid && wr_addr == REG_HOLD && !en_q) hold_q <= wr_data[HOLD_W-1:0];
      if (wr_valid && wr_addr == REG_REFRESH && !en_q) refresh_q <= wr_data[REFRESH_W-1:0];
    end
  end
endmodule

// File: rtl/sh_busy_sync.sv
module sh_busy_sync #(
  parameter int SYNC_TICKS = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic slow_tick,
  input  logic set,
  output logic busy
);
  localparam int CNT_W = (SYNC_TICKS > 1) ? $clog2(SYNC_TICKS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SYNC_TICKS - 1);

  logic [CNT_W-1:0] tick_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      tick_cnt <= '0;
    end else if (set) begin
      busy     <= 1'b1;
      tick_cnt <= '0;
    end else if (busy && slow_tick) begin
      if (tick_cnt == LAST) begin
        busy     <= 1'b0;
        tick_cnt <= '0;
      end else begin
        tick_cnt <= tick_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sh_phase_seq.sv
module sh_phase_seq #(
  parameter int SAMPLE_W  = 10,
  parameter int HOLD_W    = 10,
  parameter int REFRESH_W = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 active,
  input  logic                 slow_tick,
  input  logic [SAMPLE_W-1:0]  sample_len,
  input  logic [HOLD_W-1:0]    hold_len,
  input  logic [REFRESH_W-1:0] refresh_len,
  output logic                 ph_sample,
  output logic                 ph_hold,
  output logic                 ph_refresh,
  output logic                 start
);
  localparam int W_SH  = (SAMPLE_W > HOLD_W) ? SAMPLE_W : HOLD_W;
  localparam int CNT_W = (W_SH > REFRESH_W) ? W_SH : REFRESH_W;

  logic [CNT_W-1:0] remain;
  logic [CNT_W-1:0] span_sample, span_hold, span_refresh;
  logic             idle;

  function automatic logic [CNT_W-1:0] span(input logic [CNT_W-1:0] v);
    return (v == '0) ? CNT_W'(1) : v;
  endfunction

  assign span_sample  = span(CNT_W'(sample_len));
  assign span_hold    = span(CNT_W'(hold_len));
  assign span_refresh = span(CNT_W'(refresh_len));
  assign idle         = !(ph_sample || ph_hold || ph_refresh);
  assign start        = active && idle;

  always_ff @(posedge clk) begin
    if (rst || !active) begin
      ph_sample  <= 1'b0;
      ph_hold    <= 1'b0;
      ph_refresh <= 1'b0;
      remain     <= '0;
    end else if (idle) begin
      ph_sample <= 1'b1;
      remain    <= span_sample;
    end else if (slow_tick) begin
      if (remain == CNT_W'(1)) begin
        if (ph_hold) begin
          ph_hold    <= 1'b0;
          ph_refresh <= 1'b1;
          remain     <= span_refresh;
        end else begin
          ph_sample  <= 1'b0;
          ph_refresh <= 1'b0;
          ph_hold    <= 1'b1;
          remain     <= span_hold;
        end
      end else begin
        remain <= remain - 1'b1;
      end
    end
  end
endmodule

// File: rtl/sh_timing_seq.sv
module sh_timing_seq
  import sh_seq_pkg::*;
#(
  parameter int SAMPLE_W   = 10,
  parameter int HOLD_W     = 10,
  parameter int REFRESH_W  = 8,
  parameter int WR_W       = 16,
  parameter int SYNC_TICKS = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 slow_tick,
  input  logic                 wr_valid,
  input  logic [1:0]           wr_addr,
  input  logic [WR_W-1:0]      wr_data,
  output logic                 ph_sample,
  output logic                 ph_hold,
  output logic                 ph_refresh,
  output logic                 busy,
  output logic                 chan_en,
  output logic                 cal_en,
  output logic [2:0]           mode,
  output logic [SAMPLE_W-1:0]  sample_time,
  output logic [HOLD_W-1:0]    hold_time,
  output logic [REFRESH_W-1:0] refresh_time
);
  logic samp_accept;
  logic seq_start;
  logic active;

  sh_cfg_regs #(
    .SAMPLE_W(SAMPLE_W), .HOLD_W(HOLD_W), .REFRESH_W(REFRESH_W), .WR_W(WR_W)
  ) u_cfg (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .busy(busy), .en_q(chan_en), .cal_q(cal_en), .mode_q(mode),
    .sample_q(sample_time), .hold_q(hold_time), .refresh_q(refresh_time),
    .samp_accept(samp_accept)
  );

  assign active = chan_en && !cal_en && mode[MODE_SH_BIT];

  sh_busy_sync #(.SYNC_TICKS(SYNC_TICKS)) u_busy (
    .clk(clk), .rst(rst), .slow_tick(slow_tick),
    .set(samp_accept || seq_start), .busy(busy)
  );

  sh_phase_seq #(
    .SAMPLE_W(SAMPLE_W), .HOLD_W(HOLD_W), .REFRESH_W(REFRESH_W)
  ) u_seq (
    .clk(clk), .rst(rst), .active(active), .slow_tick(slow_tick),
    .sample_len(sample_time), .hold_len(hold_time), .refresh_len(refresh_time),
    .ph_sample(ph_sample), .ph_hold(ph_hold), .ph_refresh(ph_refresh),
    .start(seq_start)
  );
endmodule

// File: rtl/sh_timing_seq_chk.sv
module sh_timing_seq_chk #(
  parameter int SAMPLE_W = 10,
  parameter int HOLD_W   = 10
) (
  input logic                clk,
  input logic                rst,
  input logic                slow_tick,
  input logic                wr_valid,
  input logic [1:0]          wr_addr,
  input logic                ph_sample,
  input logic                ph_hold,
  input logic                ph_refresh,
  input logic                busy,
  input logic                chan_en,
  input logic                cal_en,
  input logic [2:0]          mode,
  input logic [SAMPLE_W-1:0] sample_time,
  input logic [HOLD_W-1:0]   hold_time
);
  logic runnable;
  assign runnable = chan_en && !cal_en && mode[2];

  // R8
  one_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ph_sample, ph_hold, ph_refresh}));

  // R8
  no_resample_chk: assert property (@(posedge clk) disable iff (rst)
    (ph_hold || ph_refresh) |=> !ph_sample);

  // R7
  hold_waits_tick_chk: assert property (@(posedge clk) disable iff (rst)
    (ph_hold && !slow_tick && runnable) |=> ph_hold);

  // R9
  idle_when_off_chk: assert property (@(posedge clk) disable iff (rst)
    !runnable |=> !(ph_sample || ph_hold || ph_refresh));

  // R4
  busy_write_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && wr_addr == 2'd1 && chan_en && busy) |=> $stable(sample_time));

  // R3
  hold_locked_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && wr_addr == 2'd2 && chan_en) |=> $stable(hold_time));

  // R2
  cal_locked_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && wr_addr == 2'd0 && chan_en) |=> $stable(cal_en));

  // R5
  busy_needs_tick_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !slow_tick) |=> busy);
endmodule

bind sh_timing_seq sh_timing_seq_chk #(.SAMPLE_W(SAMPLE_W), .HOLD_W(HOLD_W)) u_chk (.*);

// File: tb/test_sh_timing_seq.sv
module test_sh_timing_seq;
  localparam int CLK_PERIOD = 10;
  localparam int SYNC = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic slow_tick = 1'b0;
  logic wr_valid = 1'b0;
  logic [1:0] wr_addr = 2'd0;
  logic [15:0] wr_data = 16'd0;
  logic ph_sample, ph_hold, ph_refresh, busy, chan_en, cal_en;
  logic [2:0] mode;
  logic [9:0] sample_time, hold_time;
  logic [7:0] refresh_time;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  sh_timing_seq i_sh_timing_seq (
    .clk(clk), .rst(rst), .slow_tick(slow_tick), .wr_valid(wr_valid),
    .wr_addr(wr_addr), .wr_data(wr_data), .ph_sample(ph_sample), .ph_hold(ph_hold),
    .ph_refresh(ph_refresh), .busy(busy), .chan_en(chan_en), .cal_en(cal_en),
    .mode(mode), .sample_time(sample_time), .hold_time(hold_time),
    .refresh_time(refresh_time)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference model
  int m_en, m_cal, m_mode, m_samp, m_hold, m_ref, m_busy, m_bc, m_ph, m_cnt;
  initial begin
    m_en = 0; m_cal = 0; m_mode = 0; m_samp = 0; m_hold = 0; m_ref = 0;
    m_busy = 0; m_bc = 0; m_ph = 0; m_cnt = 0;
  end

  function automatic int len(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_en = 0; m_cal = 0; m_mode = 0; m_samp = 0; m_hold = 0; m_ref = 0;
      m_busy = 0; m_bc = 0; m_ph = 0; m_cnt = 0;
    end else begin
      int o_en, o_cal, o_mode, o_busy, o_ph, o_samp, o_hold, o_ref;
      bit act, acc;
      o_en = m_en; o_cal = m_cal; o_mode = m_mode; o_busy = m_busy; o_ph = m_ph;
      o_samp = m_samp; o_hold = m_hold; o_ref = m_ref;
      act = (o_en == 1) && (o_cal == 0) && (o_mode >= 4);
      acc = wr_valid && wr_addr == 2'd1 && (o_en == 0 || o_busy == 0);
      if (acc || (act && o_ph == 0)) begin
        m_busy = 1; m_bc = 0;
      end else if (o_busy == 1 && slow_tick) begin
        if (m_bc == SYNC - 1) begin m_busy = 0; m_bc = 0; end
        else m_bc = m_bc + 1;
      end
      if (!act) begin
        m_ph = 0; m_cnt = 0;
      end else if (o_ph == 0) begin
        m_ph = 1; m_cnt = len(o_samp);
      end else if (slow_tick) begin
        if (m_cnt == 1) begin
          if (o_ph == 2) begin m_ph = 3; m_cnt = len(o_ref); end
          else begin m_ph = 2; m_cnt = len(o_hold); end
        end else m_cnt = m_cnt - 1;
      end
      if (wr_valid) begin
        case (wr_addr)
          2'd0: begin
            m_en = int'(wr_data[0]);
            if (o_en == 0) m_cal = int'(wr_data[1]);
            if (o_en == 0 && o_cal == 0) m_mode = int'(wr_data[4:2]);
          end
          2'd1: if (acc) m_samp = int'(wr_data[9:0]);
          2'd2: if (o_en == 0) m_hold = int'(wr_data[9:0]);
          default: if (o_en == 0) m_ref = int'(wr_data[7:0]);
        endcase
      end
    end
  end

  task automatic cmp(input string tag, input int act_v, input int exp_v);
    n_cmp++;
    if (act_v != exp_v) begin
      n_bad++;
      $display("FAIL %s t=%0t actual=%0d expected=%0d", tag, $time, act_v, exp_v);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      cmp("R8 ph_sample", int'(ph_sample), int'(m_ph == 1));
      cmp("R8 ph_hold", int'(ph_hold), int'(m_ph == 2));
      cmp("R8 ph_refresh", int'(ph_refresh), int'(m_ph == 3));
      cmp("R5 busy", int'(busy), m_busy);
      cmp("R2 chan_en", int'(chan_en), m_en);
      cmp("R2 cal_en", int'(cal_en), m_cal);
      cmp("R2 mode", int'(mode), m_mode);
      cmp("R4 sample_time", int'(sample_time), m_samp);
      cmp("R3 hold_time", int'(hold_time), m_hold);
      cmp("R3 refresh_time", int'(refresh_time), m_ref);
    end
  end

  task automatic step(input bit t, input bit v, input logic [1:0] a, input logic [15:0] d);
    slow_tick = t; wr_valid = v; wr_addr = a; wr_data = d;
    @(posedge clk); #2;
    slow_tick = 1'b0; wr_valid = 1'b0;
  endtask

  task automatic run(input int n, input int gap);
    for (int i = 0; i < n; i++) step((i % gap) == gap - 1, 1'b0, 2'd0, 16'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst = 1'b0;
    // R1 reset state
    cmp("R1 strobes", int'({ph_sample, ph_hold, ph_refresh, busy}), 0);
    cmp("R1 fields", int'(sample_time) + int'(hold_time) + int'(refresh_time) + int'(mode), 0);
    step(0, 1, 2'd2, 16'd2);
    step(0, 1, 2'd3, 16'd0);
    step(0, 1, 2'd1, 16'd1);
    cmp("R5 busy after write", int'(busy), 1);
    run(12, 2);
    cmp("R5 busy cleared", int'(busy), 0);
    step(0, 1, 2'd0, 16'd16);
    step(0, 1, 2'd0, 16'd17);
    step(0, 0, 2'd0, 16'd0);
    cmp("R6 sample strobe", int'(ph_sample), 1);
    run(60, 3);
    step(0, 1, 2'd2, 16'd7);
    cmp("R3 hold write ignored", int'(hold_time), 2);
    step(0, 1, 2'd0, 16'd3);
    cmp("R2 cal locked", int'(cal_en), 0);
    cmp("R2 mode locked", int'(mode), 4);
    run(20, 1);
    step(0, 1, 2'd1, 16'd5);
    cmp("R4 sample accepted", int'(sample_time), 5);
    step(0, 1, 2'd1, 16'd9);
    cmp("R4 sample dropped busy", int'(sample_time), 5);
    step(1, 0, 2'd0, 16'd0);
    step(1, 0, 2'd0, 16'd0);
    step(1, 1, 2'd1, 16'd9);
    cmp("R4 collision write dropped", int'(sample_time), 5);
    cmp("R5 collision busy falls", int'(busy), 0);
    run(40, 2);
    step(0, 1, 2'd0, 16'd16);
    step(0, 0, 2'd0, 16'd0);
    cmp("R9 idle after disable", int'({ph_sample, ph_hold, ph_refresh}), 0);
    step(0, 1, 2'd0, 16'd18);
    cmp("R2 cal set", int'(cal_en), 1);
    step(0, 1, 2'd0, 16'd2);
    cmp("R2 mode kept under cal", int'(mode), 4);
    step(0, 1, 2'd0, 16'd19);
    run(5, 1);
    cmp("R6 no run under cal", int'({ph_sample, ph_hold, ph_refresh}), 0);
    step(0, 1, 2'd0, 16'd16);
    step(0, 1, 2'd0, 16'd16);
    cmp("R2 cal cleared", int'(cal_en), 0);
    step(0, 1, 2'd2, 16'd0);
    step(0, 1, 2'd3, 16'd0);
    step(0, 1, 2'd1, 16'd0);
    step(0, 1, 2'd0, 16'd17);
    step(0, 0, 2'd0, 16'd0);
    cmp("R6 start zero fields", int'(ph_sample), 1);
    step(1, 0, 2'd0, 16'd0);
    cmp("R7 zero sample one tick", int'(ph_hold), 1);
    step(1, 0, 2'd0, 16'd0);
    cmp("R8 refresh after hold", int'(ph_refresh), 1);
    step(1, 0, 2'd0, 16'd0);
    cmp("R8 hold after refresh", int'(ph_hold), 1);
    run(30, 1);
    step(0, 1, 2'd0, 16'd16);
    step(0, 1, 2'd2, 16'd20);
    step(0, 1, 2'd3, 16'd255);
    step(0, 1, 2'd0, 16'd17);
    run(600, 1);
    step(0, 1, 2'd0, 16'd16);
    run(3, 1);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule